// File: doc/BRIEF.md
# Pixel Sample Strobe Generator

This block runs on the master clock. It turns an external per-pixel synchronisation input into three one-cycle strobes for an analogue sampling front end: a video-sample strobe, a reset-level-sample strobe and a clamp strobe. The sync input passes through a two-flop synchroniser first. After that it is used in one of two ways. In the plain mode, the synchronised level acts as the internal sync pulse. In the detect mode, a chosen edge of any clock-rate signal creates a one-clock internal pulse, which can then be delayed by 0 to 7 master clocks.

All strobes of a pixel come from the falling edge of its internal sync pulse. The nominal reset-sample strobe comes a fixed number of clocks (parameter `RS_LEAD`, default 3) before the video strobe. A 2-bit field can move it one clock earlier, or one or two clocks later. Because every strobe is produced after the sync pulse that caused it, no strobe can come before its pixel's sync. A clamp-enable input is sampled while the internal sync is high. That sample decides whether the clamp strobe fires together with the reset strobe of the same pixel. The block supports master-clock-to-sync ratios of 2:1, 3:1, 6:1 and any even ratio of 8 or more.

Top module: `pix_strobe_gen`

## Requirements
- R1: With `det_en` low, the video strobe is high for the one cycle after the sixth rising clock edge that follows the first edge sampling `sync_in` low after a high pulse. `det_delay` and `det_rising` have no effect in this mode.
- R2: With `det_en` high, `det_rising` = 1 selects rising edges of `sync_in` and `det_rising` = 0 selects falling edges. The other edge and a steady level produce no strobe.
- R3: In detect mode, let s be the first clock edge that samples the selected edge's new level. The video strobe is high for the one cycle after edge s+7+d, where d is the value of `det_delay` (0 to 7).
- R4: Each pixel produces exactly one video strobe, one cycle wide.
- R5: The reset strobe is a one-cycle pulse that leads the video strobe by 4 − c cycles, where c is `rs_shift`. The codes are: 0 = one earlier than nominal (lead 4), 1 = nominal (lead 3), 2 = one later (lead 2), 3 = two later (lead 1).
- R6: The clamp strobe of a pixel equals its reset strobe if `clamp_en` was high at the last edge on which the internal sync was high. In plain mode that is edge s+W+1, where the pin is high for W edges starting at s. In detect mode it is edge s+2+d. Otherwise the clamp strobe stays low.
- R7: While `rst_n` is low, and after release until the first pixel, all three strobes are low.
- R8: At a 2:1 clock-to-sync ratio, back-to-back pixels each get their own full strobe set and their own clamp decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External pixel sync or clock-rate signal |
| det_en | input | 1 | 1 = derive sync from a detected edge |
| det_rising | input | 1 | Detect edge: 1 rising, 0 falling |
| det_delay | input | DLY_W | Detect-mode delay in master clocks |
| rs_shift | input | 2 | Reset/clamp strobe timing code |
| clamp_en | input | 1 | Per-pixel clamp enable, sampled during sync |
| video_stb | output | 1 | Video-sample strobe |
| reset_stb | output | 1 | Reset-level-sample strobe |
| clamp_stb | output | 1 | Clamp strobe |

## Verification
At a 2:1 ratio, one pixel's late reset and clamp strobes can land in the same cycle as the previous pixel's video strobe. In that same window, the next pixel's clamp enable is being sampled while the previous pixel's fall event is still being registered. The bench provokes this overlap by sweeping the 2:1 ratio over all four shift codes. It uses clamp values that change per pixel and drives them edge by edge. Every output is compared in every cycle against event trains computed from the latency formulas, so any strobe that goes missing, merges with another or carries another pixel's clamp decision is reported.

// File: rtl/pix_strobe_pkg.sv
package pix_strobe_pkg;

  // Reset-sample / clamp timing code
  typedef enum logic [1:0] {
    RS_ADV1 = 2'd0,
    RS_NOM  = 2'd1,
    RS_LAG1 = 2'd2,
    RS_LAG2 = 2'd3
  } rs_shift_e;

  localparam int SYNC_FLOPS = 2;

endpackage

// File: rtl/ps_sync_chain.sv
module ps_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic lvl_prev
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign lvl      = sh_q[STAGES-1];
  assign lvl_prev = sh_q[STAGES];
endmodule

// File: rtl/ps_sync_detect.sv
module ps_sync_detect #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             lvl_prev,
  input  logic             det_en,
  input  logic             det_rising,
  input  logic [DLY_W-1:0] det_delay,
  output logic             int_sync
);
  localparam int TAPS = 1 << DLY_W;

  logic            edge_hit;
  logic [TAPS-2:0] dly_q, dly_d;
  logic [TAPS-1:0] taps;
  logic            dly_en;

  always_comb begin
    edge_hit = det_rising ? (lvl & ~lvl_prev) : (~lvl & lvl_prev);
    dly_en   = det_en;
    dly_d    = dly_q;
    if (dly_en) dly_d = {dly_q[TAPS-3:0], edge_hit};
    taps     = {dly_q, edge_hit};
    int_sync = det_en ? taps[det_delay] : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  // R2: a detected pulse lasts exactly one master clock
  p_pulse_1clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && int_sync) |=> !int_sync);
endmodule

// File: rtl/ps_strobe_pipe.sv
module ps_strobe_pipe
  import pix_strobe_pkg::*;
#(
  parameter int RS_LEAD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       int_sync,
  input  logic       clamp_en,
  input  logic [1:0] rs_shift,
  output logic       video_stb,
  output logic       reset_stb,
  output logic       clamp_stb
);
  localparam int PIPE_LEN = RS_LEAD + 2;
  localparam int VS_IDX   = RS_LEAD + 1;

  logic                sync_q, clamp_lat_q, clamp_lat_d;
  logic                fall_ev;
  logic [PIPE_LEN-1:0] vld_q, vld_d, clm_q, clm_d;
  rs_shift_e           sel;

  always_comb begin
    fall_ev     = sync_q & ~int_sync;
    clamp_lat_d = int_sync ? clamp_en : clamp_lat_q;
    vld_d       = {vld_q[PIPE_LEN-2:0], fall_ev};
    clm_d       = {clm_q[PIPE_LEN-2:0], fall_ev & clamp_lat_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q      <= 1'b0;
      clamp_lat_q <= 1'b0;
    end else begin
      sync_q      <= int_sync;
      clamp_lat_q <= clamp_lat_d;
    end
  end

  for (genvar k = 0; k < PIPE_LEN; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[k] <= 1'b0;
        clm_q[k] <= 1'b0;
      end else begin
        vld_q[k] <= vld_d[k];
        clm_q[k] <= clm_d[k];
      end
    end
  end

  always_comb begin
    sel = rs_shift_e'(rs_shift);
    unique case (sel)
      RS_ADV1: begin reset_stb = vld_q[0]; clamp_stb = clm_q[0]; end
      RS_NOM:  begin reset_stb = vld_q[1]; clamp_stb = clm_q[1]; end
      RS_LAG1: begin reset_stb = vld_q[2]; clamp_stb = clm_q[2]; end
      default: begin reset_stb = vld_q[3]; clamp_stb = clm_q[3]; end
    endcase
  end

  assign video_stb = vld_q[VS_IDX];

  // R4: video strobe never longer than one cycle
  p_video_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    video_stb |=> !video_stb);
  // R6: clamp only ever accompanies a reset strobe
  p_clamp_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_stb |-> reset_stb);
  // R6: clamp decision only changes while internal sync is high
  p_lat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !int_sync |=> $stable(clamp_lat_q));
endmodule

// File: rtl/pix_strobe_gen.sv
module pix_strobe_gen
  import pix_strobe_pkg::*;
#(
  parameter int DLY_W   = 3,
  parameter int RS_LEAD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             det_en,
  input  logic             det_rising,
  input  logic [DLY_W-1:0] det_delay,
  input  logic [1:0]       rs_shift,
  input  logic             clamp_en,
  output logic             video_stb,
  output logic             reset_stb,
  output logic             clamp_stb
);
  logic [1:0] rst_q;
  logic       srst_n;
  logic       lvl, lvl_prev, int_sync;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  ps_sync_chain #(.STAGES(SYNC_FLOPS)) u_sync (
    .clk(clk), .rst_n(srst_n), .din(sync_in),
    .lvl(lvl), .lvl_prev(lvl_prev)
  );

  ps_sync_detect #(.DLY_W(DLY_W)) u_det (
    .clk(clk), .rst_n(srst_n), .lvl(lvl), .lvl_prev(lvl_prev),
    .det_en(det_en), .det_rising(det_rising), .det_delay(det_delay),
    .int_sync(int_sync)
  );

  ps_strobe_pipe #(.RS_LEAD(RS_LEAD)) u_pipe (
    .clk(clk), .rst_n(srst_n), .int_sync(int_sync), .clamp_en(clamp_en),
    .rs_shift(rs_shift), .video_stb(video_stb), .reset_stb(reset_stb),
    .clamp_stb(clamp_stb)
  );
endmodule

// File: tb/tb_pix_strobe_gen.sv
`timescale 1ns/1ps
module tb_pix_strobe_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic       det_en = 1'b0;
  logic       det_rising = 1'b0;
  logic [2:0] det_delay = 3'd0;
  logic [1:0] rs_shift = 2'd1;
  logic       clamp_en = 1'b0;
  logic       video_stb, reset_stb, clamp_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int sc_b, sc_ratio, sc_npix, sc_w, sc_d, sc_c, sc_seed, sc_off, sc_xoff;
  bit sc_pt, sc_rise;

  pix_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .det_en(det_en),
    .det_rising(det_rising), .det_delay(det_delay), .rs_shift(rs_shift),
    .clamp_en(clamp_en), .video_stb(video_stb), .reset_stb(reset_stb),
    .clamp_stb(clamp_stb)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic bit cbit(int p);
    return ((p * 7 + sc_seed) % 3) != 0;
  endfunction

  function automatic bit pin_at(int e);
    int r = e - sc_b - 2;
    bit act = 1'b0;
    if (r >= 0 && r < sc_npix * sc_ratio)
      act = sc_pt ? ((r % sc_ratio) < sc_w) : ((r % sc_ratio) < sc_ratio / 2);
    if (sc_pt || sc_rise) return act;
    return !act;
  endfunction

  function automatic bit clamp_at(int e);
    int k = e - sc_b - 2 - sc_off;
    if (k < 0 || k / sc_ratio >= sc_npix) return 1'b0;
    return cbit(k / sc_ratio);
  endfunction

  // returns pixel index + 1 if an event with this lag lands after edge e
  function automatic int ev(int e, int lag);
    int k = e - sc_b - 2 - sc_xoff - lag;
    if (k < 0 || (k % sc_ratio) != 0 || k / sc_ratio >= sc_npix) return 0;
    return k / sc_ratio + 1;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc %0d actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic do_reset(bit pt, bit rise, int d, int c);
    @(negedge clk);
    rst_n = 1'b0;
    det_en = !pt; det_rising = rise; det_delay = 3'(d); rs_shift = 2'(c);
    clamp_en = 1'b0;
    sync_in = pt ? 1'b0 : !rise;
    repeat (3) begin
      @(negedge clk);
      chk("R7 video", video_stb, 1'b0);
      chk("R7 reset", reset_stb, 1'b0);
      chk("R7 clamp", clamp_stb, 1'b0);
    end
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk("R7 video", video_stb, 1'b0);
      chk("R7 reset", reset_stb, 1'b0);
      chk("R7 clamp", clamp_stb, 1'b0);
    end
  endtask

  task automatic run(bit pt, bit rise, int ratio, int w, int d, int c, int npix);
    int total, vcount, pr, pv;
    string vtag;
    do_reset(pt, rise, d, c);
    sc_pt = pt; sc_rise = rise; sc_ratio = ratio; sc_w = w; sc_d = d;
    sc_c = c; sc_npix = npix; sc_seed = c + d + w;
    sc_off  = pt ? w + 1 : 2 + d;
    sc_xoff = pt ? w + 2 : 3 + d;
    sc_b = cyc;
    vtag = pt ? "R1 video" : (rise ? "R3 video rising R2" : "R3 video falling R2");
    total = 2 + npix * ratio + sc_xoff + 10;
    vcount = 0;
    sync_in = pin_at(cyc + 1);
    clamp_en = clamp_at(cyc + 1);
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      pv = ev(cyc, 4);
      pr = ev(cyc, c);
      if (video_stb === 1'b1) vcount++;
      chk(vtag, video_stb, pv != 0);
      chk("R5 reset", reset_stb, pr != 0);
      chk("R6 clamp", clamp_stb, (pr != 0) && cbit(pr - 1));
      sync_in = pin_at(cyc + 1);
      clamp_en = clamp_at(cyc + 1);
    end
    chk("R4 video count", vcount == npix, 1'b1);
    if (ratio == 2) chk("R8 back-to-back count", vcount == npix, 1'b1);
  endtask

  initial begin
    int ratios [4] = '{2, 3, 6, 8};
    // R1, R4, R5, R6, R8: plain mode, detect fields set to values that must be ignored
    foreach (ratios[ri]) begin
      for (int wi = 0; wi < 2; wi++) begin
        for (int c = 0; c < 4; c++) begin
          run(1'b1, 1'(c & 1), ratios[ri], (wi == 0) ? 1 : ratios[ri] - 1,
              5 - c, c, 6);
        end
      end
    end
    // R2, R3, R5, R6, R8: detect mode over both edges, all delays, all codes
    for (int rise = 0; rise < 2; rise++) begin
      for (int d = 0; d < 8; d++) begin
        for (int c = 0; c < 4; c++) begin
          run(1'b0, 1'(rise), 2, 1, d, c, 6);
          run(1'b0, 1'(rise), 6, 1, d, c, 4);
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule